// File: doc/BRIEF.md
# Inbound Message Queue Controller

This block takes inbound message segments from a packet interface and stores each completed message as one frame in a circular queue in local memory. Two controller instances share the block; the mailbox number of a segment selects which one receives it. Each instance keeps a fill pointer, a software-visible enqueue pointer, a dequeue pointer, an interrupt enable and a message-in-queue flag. Segment writes leave the block on a single valid/ready memory write port.

Every segment that is taken on the input gets a response code one cycle later. The segment is either accepted or answered with a logical-layer retry. A retry has one of three causes: the target queue has no free frame, the segment belongs to a different stream while a multi-segment message is being assembled, or a new message has a higher priority than every write still waiting to reach memory. Software walks the queue through a small register map. It can step the dequeue pointer with an increment bit or write it directly. It polls an empty bit and clears the interrupt flag by writing 1 to it.

Top module: `imq_top`

## Requirements
- R1: A segment with mailbox 0 goes to controller 0. A segment with mailbox 1, 2 or 3 goes to controller 1.
- R2: In the cycle after a segment is taken (seg_valid and seg_ready), resp_valid is 1 and resp_code carries the result: 0 accepted, 1 queue full, 2 stream conflict, 3 priority conflict. In every other cycle resp_valid is 0.
- R3: When no message is being assembled and advancing the fill pointer by one would make it equal the dequeue pointer, a new segment is answered with code 1 and nothing is written.
- R4: While a multi-segment message is being assembled, a segment whose source ID, destination ID or mailbox differs from that message is answered with code 2. Segments of the same stream are accepted.
- R5: A new message whose priority is higher than every write still pending in its controller is answered with code 3. A message of equal or lower priority is accepted.
- R6: An accepted segment is written to address BASE + slot*4 + segment index, where slot is the frame being filled and BASE is 0x000 for controller 0 and 0x100 for controller 1. While mem_valid is high and mem_ready is low, mem_addr and mem_wdata hold steady.
- R7: The enqueue pointer advances by one frame (mod 8), and the message-in-queue flag sets, only when the final segment of a message has been written to memory. Earlier segments change neither.
- R8: Writing the mode register with bit 0 set advances the dequeue pointer by one frame (mod 8). The write has no effect while the queue is empty.
- R9: Status bit 0 reads 1 exactly when the dequeue pointer equals the enqueue pointer. Status bit 1 is the message-in-queue flag, and writing 1 to it clears it.
- R10: irq[i] equals controller i's message-in-queue flag ANDed with its enable (mode bit 1), and stays high until the flag is cleared.
- R11: Register 2 reads the enqueue pointer. Register 3 reads the dequeue pointer and can be written directly; a written value of 8 or more is ignored.
- R12: reg_addr[2] selects the controller and reg_addr[1:0] selects the register (0 mode, 1 status, 2 enqueue, 3 dequeue). reg_rdata shows the addressed register one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_valid | input | 1 | Segment present |
| seg_ready | output | 1 | Target controller can take a segment |
| seg_src | input | 8 | Source ID |
| seg_dst | input | 8 | Destination ID |
| seg_mbox | input | 2 | Mailbox number |
| seg_prio | input | 2 | Priority, 3 highest |
| seg_idx | input | 2 | Segment index within the message |
| seg_last | input | 1 | Final segment of the message |
| seg_data | input | 32 | Segment payload |
| resp_valid | output | 1 | Response for the segment taken in the previous cycle |
| resp_code | output | 2 | 0 accept, 1 full, 2 stream, 3 priority |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 16 | Word address of the write |
| mem_wdata | output | 32 | Write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Controller select and register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 2 | Per-controller message-in-queue interrupt |

## Verification
The priority retry is the hardest case to reach. It needs a write that is still pending in memory, from a message that has already been closed, when a higher-priority message starts in the same controller. The stimulus holds mem_ready low across a table of segments so that writes pile up in the buffer. It then sends a priority-2 message after priority-0 writes (retried) and a priority-0 message (accepted). The full case is reached by filling all seven usable frames with single-segment messages before sending an eighth.

// File: rtl/imq_pkg.sv
package imq_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_FULL   = 2'd1,
    RSP_STREAM = 2'd2,
    RSP_PRIO   = 2'd3
  } rsp_e;

  localparam logic [1:0] RIDX_MODE = 2'd0;
  localparam logic [1:0] RIDX_STAT = 2'd1;
  localparam logic [1:0] RIDX_ENQ  = 2'd2;
  localparam logic [1:0] RIDX_DEQ  = 2'd3;
endpackage

// File: rtl/imq_wbuf.sv
module imq_wbuf #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dout  = store[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/imq_ctrl.sv
module imq_ctrl
  import imq_pkg::*;
#(
  parameter int SID_W   = 8,
  parameter int MBOX_W  = 2,
  parameter int PRIO_W  = 2,
  parameter int SEG_W   = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int NFRAMES = 8,
  parameter int BASE    = 0,
  parameter int FDEPTH  = 4,
  parameter int PTR_W   = $clog2(NFRAMES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_fire,
  input  logic [SID_W-1:0]  seg_src,
  input  logic [SID_W-1:0]  seg_dst,
  input  logic [MBOX_W-1:0] seg_mbox,
  input  logic [PRIO_W-1:0] seg_prio,
  input  logic [SEG_W-1:0]  seg_idx,
  input  logic              seg_last,
  input  logic [DATA_W-1:0] seg_data,
  output logic              seg_ready,
  output rsp_e              rsp,
  output logic              hd_valid,
  output logic [ADDR_W-1:0] hd_addr,
  output logic [DATA_W-1:0] hd_data,
  input  logic              hd_pop,
  input  logic              reg_wr,
  input  logic [1:0]        reg_idx,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [PTR_W-1:0]  enq_ptr,
  output logic [PTR_W-1:0]  deq_ptr,
  output logic              miq,
  output logic              irq_en
);
  localparam int NPRIO = 1 << PRIO_W;
  localparam int CW    = $clog2(FDEPTH + 1);
  localparam int EW    = 1 + PRIO_W + ADDR_W + DATA_W;

  logic              act_q;
  logic [SID_W-1:0]  act_src_q, act_dst_q;
  logic [MBOX_W-1:0] act_mbox_q;
  logic [PTR_W-1:0]  wptr_q, enq_q, deq_q;
  logic              en_q, miq_q;
  logic [CW-1:0]     pcnt [NPRIO];

  logic              fb_full, fb_empty, push;
  logic [EW-1:0]     fb_din, fb_dout;
  logic              hd_last;
  logic [PRIO_W-1:0] hd_prio;
  logic              same_stream, q_full, any_ge, commit, q_empty;
  logic              inc_req, deq_wr, w1c_miq;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NFRAMES - 1)) ? '0 : p + 1'b1;
  endfunction

  assign same_stream = (seg_src == act_src_q) && (seg_dst == act_dst_q) &&
                       (seg_mbox == act_mbox_q);
  assign q_full      = (nxt(wptr_q) == deq_q);
  assign q_empty     = (enq_q == deq_q);

  always_comb begin
    any_ge = 1'b0;
    for (int p = 0; p < NPRIO; p++)
      if (PRIO_W'(p) >= seg_prio && pcnt[p] != '0) any_ge = 1'b1;
  end

  always_comb begin
    if (act_q)                  rsp = same_stream ? RSP_OK : RSP_STREAM;
    else if (q_full)            rsp = RSP_FULL;
    else if (!fb_empty && !any_ge) rsp = RSP_PRIO;
    else                        rsp = RSP_OK;
  end

  assign seg_ready = !fb_full;
  assign push      = seg_fire && (rsp == RSP_OK);

  assign fb_din = {seg_last, seg_prio,
                   ADDR_W'(BASE) + (ADDR_W'(wptr_q) << SEG_W) + ADDR_W'(seg_idx),
                   seg_data};

  imq_wbuf #(.WIDTH(EW), .DEPTH(FDEPTH)) u_wbuf (
    .clk(clk), .rst(rst), .push(push), .din(fb_din), .pop(hd_pop),
    .dout(fb_dout), .full(fb_full), .empty(fb_empty)
  );

  assign {hd_last, hd_prio, hd_addr, hd_data} = fb_dout;
  assign hd_valid = !fb_empty;
  assign commit   = hd_pop && hd_last;

  generate
    for (genvar p = 0; p < NPRIO; p++) begin : g_pcnt
      logic up, dn;
      assign up = push && (seg_prio == PRIO_W'(p));
      assign dn = hd_pop && (hd_prio == PRIO_W'(p));
      always_ff @(posedge clk) begin
        if (rst)            pcnt[p] <= '0;
        else if (up && !dn) pcnt[p] <= pcnt[p] + 1'b1;
        else if (dn && !up) pcnt[p] <= pcnt[p] - 1'b1;
      end
    end
  endgenerate

  // message assembly and fill pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      act_src_q  <= '0;
      act_dst_q  <= '0;
      act_mbox_q <= '0;
      wptr_q     <= '0;
    end else if (push) begin
      if (seg_last) begin
        act_q  <= 1'b0;
        wptr_q <= nxt(wptr_q);
      end else begin
        act_q      <= 1'b1;
        act_src_q  <= seg_src;
        act_dst_q  <= seg_dst;
        act_mbox_q <= seg_mbox;
      end
    end
  end

  assign inc_req = reg_wr && (reg_idx == RIDX_MODE) && reg_wdata[0];
  assign deq_wr  = reg_wr && (reg_idx == RIDX_DEQ) && (reg_wdata < REG_W'(NFRAMES));
  assign w1c_miq = reg_wr && (reg_idx == RIDX_STAT) && reg_wdata[1];

  // software-visible pointers and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      enq_q <= '0;
      deq_q <= '0;
      en_q  <= 1'b0;
      miq_q <= 1'b0;
    end else begin
      if (commit) enq_q <= nxt(enq_q);
      if (deq_wr)                  deq_q <= PTR_W'(reg_wdata);
      else if (inc_req && !q_empty) deq_q <= nxt(deq_q);
      if (reg_wr && reg_idx == RIDX_MODE) en_q <= reg_wdata[1];
      if (commit)       miq_q <= 1'b1;
      else if (w1c_miq) miq_q <= 1'b0;
    end
  end

  assign enq_ptr = enq_q;
  assign deq_ptr = deq_q;
  assign miq     = miq_q;
  assign irq_en  = en_q;
endmodule

// File: rtl/imq_top.sv
module imq_top
  import imq_pkg::*;
#(
  parameter int SID_W   = 8,
  parameter int MBOX_W  = 2,
  parameter int PRIO_W  = 2,
  parameter int SEG_W   = 2,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter int NFRAMES = 8,
  parameter int BASE0   = 'h000,
  parameter int BASE1   = 'h100,
  parameter int FDEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [SID_W-1:0]  seg_src,
  input  logic [SID_W-1:0]  seg_dst,
  input  logic [MBOX_W-1:0] seg_mbox,
  input  logic [PRIO_W-1:0] seg_prio,
  input  logic [SEG_W-1:0]  seg_idx,
  input  logic              seg_last,
  input  logic [DATA_W-1:0] seg_data,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [1:0]        irq
);
  localparam int NCTRL = 2;
  localparam int PTR_W = $clog2(NFRAMES);

  logic              tgt;
  logic              seg_fire;
  logic              rdy_v   [NCTRL];
  rsp_e              rsp_v   [NCTRL];
  logic              hv_v    [NCTRL];
  logic [ADDR_W-1:0] ha_v    [NCTRL];
  logic [DATA_W-1:0] hd_v    [NCTRL];
  logic              pop_v   [NCTRL];
  logic [PTR_W-1:0]  enq_v   [NCTRL];
  logic [PTR_W-1:0]  deq_v   [NCTRL];
  logic              miq_v   [NCTRL];
  logic              en_v    [NCTRL];
  logic              gnt, gnt_q, lock_q;

  // mailbox 0 -> controller 0, any other mailbox -> controller 1
  assign tgt       = (seg_mbox != '0);
  assign seg_ready = rdy_v[tgt];
  assign seg_fire  = seg_valid && seg_ready;

  generate
    for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
      localparam int CBASE = (i == 0) ? BASE0 : BASE1;
      imq_ctrl #(
        .SID_W(SID_W), .MBOX_W(MBOX_W), .PRIO_W(PRIO_W), .SEG_W(SEG_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NFRAMES(NFRAMES),
        .BASE(CBASE), .FDEPTH(FDEPTH), .PTR_W(PTR_W)
      ) u_ctrl (
        .clk(clk), .rst(rst),
        .seg_fire(seg_fire && (tgt == 1'(i))),
        .seg_src(seg_src), .seg_dst(seg_dst), .seg_mbox(seg_mbox),
        .seg_prio(seg_prio), .seg_idx(seg_idx), .seg_last(seg_last),
        .seg_data(seg_data), .seg_ready(rdy_v[i]), .rsp(rsp_v[i]),
        .hd_valid(hv_v[i]), .hd_addr(ha_v[i]), .hd_data(hd_v[i]),
        .hd_pop(pop_v[i]),
        .reg_wr(reg_we && (reg_addr[2] == 1'(i))),
        .reg_idx(reg_addr[1:0]), .reg_wdata(reg_wdata),
        .enq_ptr(enq_v[i]), .deq_ptr(deq_v[i]),
        .miq(miq_v[i]), .irq_en(en_v[i])
      );
      assign pop_v[i] = mem_valid && mem_ready && (gnt == 1'(i));
      assign irq[i]   = miq_v[i] && en_v[i];
    end
  endgenerate

  // memory port: controller 0 first, grant held while a write stalls
  assign gnt       = lock_q ? gnt_q : !hv_v[0];
  assign mem_valid = hv_v[gnt];
  assign mem_addr  = ha_v[gnt];
  assign mem_wdata = hd_v[gnt];

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      gnt_q  <= gnt;
      lock_q <= mem_valid && !mem_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_code  <= 2'd0;
    end else begin
      resp_valid <= seg_fire;
      resp_code  <= seg_fire ? 2'(rsp_v[tgt]) : 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr[1:0])
        RIDX_MODE: reg_rdata <= REG_W'({en_v[reg_addr[2]], 1'b0});
        RIDX_STAT: reg_rdata <= REG_W'({miq_v[reg_addr[2]],
                                        enq_v[reg_addr[2]] == deq_v[reg_addr[2]]});
        RIDX_ENQ:  reg_rdata <= REG_W'(enq_v[reg_addr[2]]);
        default:   reg_rdata <= REG_W'(deq_v[reg_addr[2]]);
      endcase
    end
  end
endmodule

// File: rtl/imq_chk.sv
module imq_chk #(
  parameter int PTR_W  = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              seg_fire,
  input logic              resp_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              reg_we,
  input logic              pop0,
  input logic              pop1,
  input logic [PTR_W-1:0]  enq0,
  input logic [PTR_W-1:0]  enq1,
  input logic [PTR_W-1:0]  deq0
);
  a_r2_resp_after_take: assert property (@(posedge clk) disable iff (rst)
    seg_fire |=> resp_valid);

  a_r2_no_stray_resp: assert property (@(posedge clk) disable iff (rst)
    !seg_fire |=> !resp_valid);

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

  a_r7_enq0_on_write: assert property (@(posedge clk) disable iff (rst)
    (enq0 != $past(enq0)) |-> $past(pop0));

  a_r7_enq1_on_write: assert property (@(posedge clk) disable iff (rst)
    (enq1 != $past(enq1)) |-> $past(pop1));

  a_r8_deq_by_sw: assert property (@(posedge clk) disable iff (rst)
    (deq0 != $past(deq0)) |-> $past(reg_we));
endmodule

bind imq_top imq_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .seg_fire(seg_fire), .resp_valid(resp_valid),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .reg_we(reg_we), .pop0(pop_v[0]), .pop1(pop_v[1]),
  .enq0(enq_v[0]), .enq1(enq_v[1]), .deq0(deq_v[0])
);

// File: tb/imq_top_tb.sv
module imq_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_valid = 1'b0, seg_ready, seg_last = 1'b0;
  logic [7:0]  seg_src = '0, seg_dst = '0;
  logic [1:0]  seg_mbox = '0, seg_prio = '0, seg_idx = '0;
  logic [31:0] seg_data = '0;
  logic        resp_valid, mem_valid, mem_ready = 1'b1, reg_we = 1'b0;
  logic [1:0]  resp_code, irq;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, reg_wdata = '0, reg_rdata;
  logic [2:0]  reg_addr = '0;
  int n_run = 0, n_fail = 0;
  logic [1:0]  got;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  imq_top u_dut (.*);

  // vector: {mrdy, mbox[2], src[8], dst[8], prio[2], idx[2], last, exp_code[2]}
  localparam logic [25:0] VEC [8] = '{
    {1'b1, 2'd0, 8'd1, 8'd1, 2'd0, 2'd0, 1'b1, 2'd0}, // R1 single to ctrl0
    {1'b0, 2'd0, 8'd1, 8'd1, 2'd0, 2'd0, 1'b0, 2'd0}, // start multi, writes stall
    {1'b0, 2'd0, 8'd2, 8'd1, 2'd0, 2'd0, 1'b1, 2'd2}, // R4 other stream
    {1'b0, 2'd1, 8'd2, 8'd1, 2'd3, 2'd0, 1'b1, 2'd0}, // R1 mbox1 -> ctrl1
    {1'b0, 2'd2, 8'd3, 8'd1, 2'd1, 2'd0, 1'b1, 2'd0}, // R5 lower prio ok
    {1'b0, 2'd0, 8'd1, 8'd1, 2'd0, 2'd1, 1'b1, 2'd0}, // R4 same stream ok
    {1'b0, 2'd0, 8'd5, 8'd5, 2'd2, 2'd0, 1'b1, 2'd3}, // R5 higher prio retried
    {1'b0, 2'd0, 8'd5, 8'd5, 2'd0, 2'd0, 1'b1, 2'd0}  // R5 equal prio ok
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic mrdy, input logic [1:0] mb, input logic [7:0] s,
                      input logic [7:0] d, input logic [1:0] p, input logic [1:0] ix,
                      input logic lst, input logic [31:0] dat, output logic [1:0] code);
    @(negedge clk);
    mem_ready = mrdy; seg_mbox = mb; seg_src = s; seg_dst = d; seg_prio = p;
    seg_idx = ix; seg_last = lst; seg_data = dat; seg_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
    check("R2 resp_valid", 32'(resp_valid), 32'd1);
    code = resp_code;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    check("R2 reset resp_valid", 32'(resp_valid), 32'd0);
    check("R10 reset irq", 32'(irq), 32'd0);
    check("R6 reset mem_valid", 32'(mem_valid), 32'd0);
    rdr(3'd1, rd); check("R9 reset status empty", rd, 32'd1);

    for (int i = 0; i < 8; i++) begin
      send(VEC[i][25], VEC[i][24:23], VEC[i][22:15], VEC[i][14:7], VEC[i][6:5],
           VEC[i][4:3], VEC[i][2], 32'h1000 + 32'(i), got);
      check($sformatf("R2 vector %0d code", i), 32'(got), 32'(VEC[i][1:0]));
      idle(2);
    end
    @(negedge clk); mem_ready = 1'b1;
    idle(12);

    rdr(3'd2, rd); check("R1 ctrl0 enq after table", rd, 32'd3);
    rdr(3'd6, rd); check("R1 ctrl1 enq after table", rd, 32'd2);
    rdr(3'd1, rd); check("R9 status ctrl0 flag set, not empty", rd, 32'd2);
    check("R10 irq masked", 32'(irq[0]), 32'd0);
    wr(3'd0, 32'd2);
    check("R10 irq enabled", 32'(irq[0]), 32'd1);
    wr(3'd1, 32'd2);
    check("R9 W1C clears flag / R10 irq low", 32'(irq[0]), 32'd0);

    for (int k = 0; k < 3; k++) wr(3'd0, 32'd3);
    rdr(3'd3, rd); check("R8 deq stepped", rd, 32'd3);
    rdr(3'd1, rd); check("R9 empty after stepping", rd, 32'd1);
    wr(3'd0, 32'd3);
    rdr(3'd3, rd); check("R8 increment ignored when empty", rd, 32'd3);

    // fill seven frames, eighth hits the full condition
    for (int k = 0; k < 7; k++) begin
      send(1'b1, 2'd0, 8'd7, 8'd7, 2'd0, 2'd0, 1'b1, 32'(k), got);
      check("R3 fill accepted", 32'(got), 32'd0);
      idle(2);
    end
    send(1'b1, 2'd0, 8'd7, 8'd7, 2'd0, 2'd0, 1'b1, 32'hEE, got);
    check("R3 full retry", 32'(got), 32'd1);
    idle(3);
    rdr(3'd2, rd); check("R3 retried message not enqueued", rd, 32'd2);

    wr(3'd3, 32'd2);
    rdr(3'd1, rd); check("R11 deq write makes empty", rd, 32'd3);
    wr(3'd3, 32'd9);
    rdr(3'd3, rd); check("R11 deq write >= 8 ignored", rd, 32'd2);
    wr(3'd1, 32'd2);

    // partial message stays invisible until its last write
    send(1'b1, 2'd0, 8'd9, 8'd9, 2'd1, 2'd0, 1'b0, 32'hA0, got);
    check("R7 first part accepted", 32'(got), 32'd0);
    idle(3);
    rdr(3'd2, rd); check("R7 enq unchanged mid-message", rd, 32'd2);
    rdr(3'd1, rd); check("R7 flag clear mid-message", rd, 32'd1);
    send(1'b1, 2'd0, 8'd9, 8'd9, 2'd1, 2'd1, 1'b1, 32'hA1, got);
    idle(3);
    rdr(3'd2, rd); check("R7 enq advanced after last write", rd, 32'd3);
    rdr(3'd1, rd); check("R7 flag set after last write", rd, 32'd2);

    // address layout on ctrl1 via mailbox 3
    send(1'b0, 2'd3, 8'd4, 8'd4, 2'd0, 2'd2, 1'b1, 32'hCAFE0003, got);
    check("R6 mem_valid", 32'(mem_valid), 32'd1);
    check("R6 mem_addr", 32'(mem_addr), 32'h10A);
    check("R6 mem_wdata", mem_wdata, 32'hCAFE0003);
    @(negedge clk); mem_ready = 1'b1;
    idle(3);
    rdr(3'd6, rd); check("R12 ctrl1 enq via addr bit2", rd, 32'd3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule